// File: doc/BRIEF.md
# Codec Power-Down and Clock-Select Controller

This block decides when a PCM voice codec is powered, which master and bit clocks feed its receive side, and which master-clock divider ratio applies. Two of its inputs are dual-purpose pins. Each of them can either carry a clock or sit at a static level. The block samples both pins in its own system clock domain. A pin that keeps toggling within a short window of transmit-master-clock periods is classed as a clock. Any other pin is classed as a static level.

A static high on the receive-master-clock pin forces power-down. Power is also dropped when no frame sync of either direction arrives for a programmable number of transmit-master-clock periods (4096 by default, about 2 ms at 2.048 MHz). A separate gate keeps the serial PCM output tri-stated after power-up until the second transmit frame sync. A static receive-bit-clock pin routes the transmit bit clock to both directions, and its level, read through the companding-law parameter, picks the 2.048 MHz ratio or the 1.536/1.544 MHz ratio.

Top module: `codec_pwr_clk_ctrl`

## Requirements
- R1: After reset, `pwr_up` and `dx_en` are 0, so the codec is held powered down with its data output tri-stated.
- R2: While the `mclkr_pdn` pin is classed as static and is high, `pwr_up` and `dx_en` are 0, whatever the frame syncs do.
- R3: When `mclkr_pdn` is static low or is toggling, a rising edge on `fsx` or `fsr` sets `pwr_up` to 1.
- R4: Each rising edge of `fsx` or `fsr` restarts a count of `mclkx` rising edges. If the count reaches TIMEOUT_CYC with no new sync, `pwr_up` drops to 0. A sync arriving earlier keeps `pwr_up` at 1.
- R5: `dx_en` becomes 1 only at the second `fsx` rising edge counted since power was last lost or forced off. `fsr` edges do not count, and `fsx` edges seen while `mclkr_pdn` forces power-down do not count.
- R6: `rx_mclk_from_tx` is 0 while `mclkr_pdn` toggles at least once every CLASS_WIN `mclkx` periods. Otherwise it is 1, meaning the transmit master clock drives the receive timing.
- R7: `rx_bclk_from_tx` is 1 while `bclkr_sel` is static and 0 while it toggles, using the same window rule as R6.
- R8: `rate_2048` (1 = 2.048 MHz ratio, 0 = 1.536/1.544 MHz ratio) follows this map. With A_LAW=1: static 0 gives 0, static 1 gives 1, clocked gives 1. With A_LAW=0: static 0 gives 1, static 1 gives 0, clocked gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled in this domain |
| rst | input | 1 | Synchronous active-high reset |
| mclkx | input | 1 | Transmit master clock, used as the time base for windows and timeout |
| mclkr_pdn | input | 1 | Receive master clock, or a static power-down level |
| bclkr_sel | input | 1 | Receive bit clock, or a static clock-ratio select level |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| pwr_up | output | 1 | Codec power enable |
| dx_en | output | 1 | Serial data output enable (0 = tri-stated) |
| rx_mclk_from_tx | output | 1 | 1: receive side uses the transmit master clock |
| rx_bclk_from_tx | output | 1 | 1: both directions use the transmit bit clock |
| rate_2048 | output | 1 | Master-clock divider select |

## Verification
In the same cycle, a new frame sync can arrive just as the silence counter reaches its limit. The sync must win, so power stays on and the counter restarts. The bench provokes this by sweeping the gap between consecutive syncs, in single `mclkx` periods, to just below the timeout and then to just beyond it. A sticky monitor records any drop of `pwr_up` during each gap. Short gaps must leave no drop. Long gaps must show a drop, after which the output gate must arm again and wait for two fresh transmit syncs.

// File: rtl/pcm_pdn_pkg.sv
package pcm_pdn_pkg;
  typedef enum logic {PWR_DOWN = 1'b0, PWR_UP = 1'b1} pwr_state_t;

  // Divider select: 1 = 2.048 MHz ratio, 0 = 1.536/1.544 MHz ratio.
  function automatic logic fast_rate(input logic a_law, input logic clocked,
                                     input logic level);
    if (clocked) return a_law;
    return a_law ? level : ~level;
  endfunction
endpackage

// File: rtl/pdn_sync_edge.sv
module pdn_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic toggle
);
  logic [STAGES-1:0] sreg;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      prev <= 1'b0;
    end else begin
      sreg <= {sreg[STAGES-2:0], din};
      prev <= sreg[STAGES-1];
    end
  end

  assign lvl    = sreg[STAGES-1];
  assign toggle = sreg[STAGES-1] ^ prev;
endmodule

// File: rtl/pdn_pin_class.sv
module pdn_pin_class #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic toggle,
  output logic is_clock
);
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_clock <= 1'b0;
      cnt      <= '0;
    end else if (toggle) begin
      is_clock <= 1'b1;
      cnt      <= '0;
    end else if (tick && is_clock) begin
      if (cnt == CW'(WIN - 1)) begin
        is_clock <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6/R7: any edge on the pin marks it as a clock on the next cycle
  p_toggle_marks_clock_r6: assert property (@(posedge clk) disable iff (rst)
    toggle |=> is_clock);
endmodule

// File: rtl/pdn_power_ctrl.sv
module pdn_power_ctrl
  import pcm_pdn_pkg::*;
#(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pdn_req,
  input  logic fsx_rise,
  input  logic fsr_rise,
  output logic pwr_up,
  output logic dx_en
);
  localparam int WW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;

  pwr_state_t    state;
  logic          sync_ok, sync_ok_n;
  logic [WW-1:0] wcnt, wcnt_n;
  logic [1:0]    txc, txc_n;
  logic          sync_any, expire, up_n;

  always_comb begin
    sync_any  = fsx_rise | fsr_rise;
    expire    = sync_ok && tick && (wcnt == WW'(TIMEOUT_CYC - 1)) && !sync_any;
    sync_ok_n = sync_any ? 1'b1 : (expire ? 1'b0 : sync_ok);
    if (sync_any || expire)  wcnt_n = '0;
    else if (sync_ok && tick) wcnt_n = wcnt + 1'b1;
    else                      wcnt_n = wcnt;
    if (pdn_req || expire)               txc_n = 2'd0;
    else if (fsx_rise && txc != 2'd2)    txc_n = txc + 2'd1;
    else                                 txc_n = txc;
    up_n = !pdn_req && sync_ok_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PWR_DOWN;
      sync_ok <= 1'b0;
      wcnt    <= '0;
      txc     <= 2'd0;
      dx_en   <= 1'b0;
    end else begin
      state   <= up_n ? PWR_UP : PWR_DOWN;
      sync_ok <= sync_ok_n;
      wcnt    <= wcnt_n;
      txc     <= txc_n;
      dx_en   <= up_n && (txc_n == 2'd2);
    end
  end

  assign pwr_up = (state == PWR_UP);

  p_pdn_forces_down_r2: assert property (@(posedge clk) disable iff (rst)
    pdn_req |=> (!pwr_up && !dx_en));
  p_expire_drops_r4: assert property (@(posedge clk) disable iff (rst)
    expire |=> !pwr_up);
  p_dx_on_tx_sync_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dx_en) |-> $past(fsx_rise));
endmodule

// File: rtl/codec_pwr_clk_ctrl.sv
module codec_pwr_clk_ctrl
  import pcm_pdn_pkg::*;
#(
  parameter bit A_LAW       = 1'b1,
  parameter int CLASS_WIN   = 4,
  parameter int TIMEOUT_CYC = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mclkx,
  input  logic mclkr_pdn,
  input  logic bclkr_sel,
  input  logic fsx,
  input  logic fsr,
  output logic pwr_up,
  output logic dx_en,
  output logic rx_mclk_from_tx,
  output logic rx_bclk_from_tx,
  output logic rate_2048
);
  localparam int NPIN = 5;
  // pin order in the vectors: 0 mclkx, 1 mclkr_pdn, 2 bclkr_sel, 3 fsx, 4 fsr
  logic [NPIN-1:0] pin_in, pin_lvl, pin_tog;
  assign pin_in = {fsr, fsx, bclkr_sel, mclkr_pdn, mclkx};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    pdn_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(pin_in[i]),
      .lvl(pin_lvl[i]), .toggle(pin_tog[i]));
  end

  logic tick, fsx_rise, fsr_rise, mr_clk, br_clk, pdn_req;
  assign tick     = pin_lvl[0] & pin_tog[0];
  assign fsx_rise = pin_lvl[3] & pin_tog[3];
  assign fsr_rise = pin_lvl[4] & pin_tog[4];

  pdn_pin_class #(.WIN(CLASS_WIN)) u_mr_class (
    .clk(clk), .rst(rst), .tick(tick), .toggle(pin_tog[1]), .is_clock(mr_clk));
  pdn_pin_class #(.WIN(CLASS_WIN)) u_br_class (
    .clk(clk), .rst(rst), .tick(tick), .toggle(pin_tog[2]), .is_clock(br_clk));

  assign pdn_req = !mr_clk && pin_lvl[1];

  pdn_power_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_pwr (
    .clk(clk), .rst(rst), .tick(tick), .pdn_req(pdn_req),
    .fsx_rise(fsx_rise), .fsr_rise(fsr_rise), .pwr_up(pwr_up), .dx_en(dx_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_mclk_from_tx <= 1'b1;
      rx_bclk_from_tx <= 1'b1;
      rate_2048       <= 1'b0;
    end else begin
      rx_mclk_from_tx <= !mr_clk;
      rx_bclk_from_tx <= !br_clk;
      rate_2048       <= fast_rate(A_LAW, br_clk, pin_lvl[2]);
    end
  end

  p_clocked_rate_r8: assert property (@(posedge clk) disable iff (rst)
    br_clk |=> (rate_2048 == A_LAW));
  p_clock_pin_own_r6: assert property (@(posedge clk) disable iff (rst)
    mr_clk |=> !rx_mclk_from_tx);
  p_bclk_route_r7: assert property (@(posedge clk) disable iff (rst)
    !br_clk |=> rx_bclk_from_tx);
endmodule

// File: tb/sim_codec_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module sim_codec_pwr_clk_ctrl;
  localparam int TO  = 32;
  localparam int WIN = 4;
  localparam int MP  = 8;   // mclkx period in clk cycles

  logic clk = 1'b0, rst = 1'b1;
  logic mclkx = 1'b0, mr_pin = 1'b0, br_pin = 1'b0, fsx = 1'b0, fsr = 1'b0;
  logic mr_run = 1'b0, br_run = 1'b0;
  logic pwr_up, dx_en, mfrom, bfrom, rate0;
  logic pwr_up1, dx_en1, mfrom1, bfrom1, rate1;
  int   n_chk = 0, n_fail = 0;
  logic mon = 1'b0, dropped = 1'b0;

  always #10 clk = ~clk;
  initial forever begin #80; mclkx = ~mclkx; end
  initial forever begin #40; if (mr_run) mr_pin = ~mr_pin; end
  initial forever begin #60; if (br_run) br_pin = ~br_pin; end

  codec_pwr_clk_ctrl #(.A_LAW(1'b1), .CLASS_WIN(WIN), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst(rst), .mclkx(mclkx), .mclkr_pdn(mr_pin), .bclkr_sel(br_pin),
    .fsx(fsx), .fsr(fsr), .pwr_up(pwr_up), .dx_en(dx_en),
    .rx_mclk_from_tx(mfrom), .rx_bclk_from_tx(bfrom), .rate_2048(rate0));
  codec_pwr_clk_ctrl #(.A_LAW(1'b0), .CLASS_WIN(WIN), .TIMEOUT_CYC(TO)) u1 (
    .clk(clk), .rst(rst), .mclkx(mclkx), .mclkr_pdn(mr_pin), .bclkr_sel(br_pin),
    .fsx(fsx), .fsr(fsr), .pwr_up(pwr_up1), .dx_en(dx_en1),
    .rx_mclk_from_tx(mfrom1), .rx_bclk_from_tx(bfrom1), .rate_2048(rate1));

  always @(negedge clk) if (mon && !pwr_up) dropped <= 1'b1;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_x();
    fsx = 1'b1; wclk(4); fsx = 1'b0;
  endtask

  task automatic pulse_r();
    fsr = 1'b1; wclk(4); fsr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wclk(5); rst = 1'b0; @(negedge clk);
    chk("R1 pwr_up", pwr_up, 1'b0);
    chk("R1 dx_en", dx_en, 1'b0);

    // static high on power-down pin, syncs running
    mr_pin = 1'b1; br_pin = 1'b0; wclk(100);
    for (int i = 0; i < 3; i++) begin pulse_x(); wclk(40); end
    @(negedge clk);
    chk("R2 pwr_up", pwr_up, 1'b0);
    chk("R2 dx_en", dx_en, 1'b0);
    chk("R6 static mclkr", mfrom, 1'b1);
    chk("R7 static bclkr", bfrom, 1'b1);
    chk("R8 alaw static0", rate0, 1'b0);
    chk("R8 ulaw static0", rate1, 1'b1);
    br_pin = 1'b1; wclk(100); @(negedge clk);
    chk("R8 alaw static1", rate0, 1'b1);
    chk("R8 ulaw static1", rate1, 1'b0);
    br_run = 1'b1; wclk(100); @(negedge clk);
    chk("R7 clocked bclkr", bfrom, 1'b0);
    chk("R8 alaw clocked", rate0, 1'b1);
    chk("R8 ulaw clocked", rate1, 1'b0);

    // release power-down after silence: no sync yet, stay down
    mr_pin = 1'b0; wclk(400); @(negedge clk);
    chk("R4 no sync keeps down", pwr_up, 1'b0);
    pulse_x(); wclk(20); @(negedge clk);
    chk("R3 up on fsx", pwr_up, 1'b1);
    chk("R5 gate after one fsx", dx_en, 1'b0);
    pulse_r(); wclk(20); @(negedge clk);
    chk("R5 fsr not counted", dx_en, 1'b0);
    pulse_x(); wclk(20); @(negedge clk);
    chk("R5 gate after second fsx", dx_en, 1'b1);

    // running receive master clock
    mr_run = 1'b1; wclk(60); @(negedge clk);
    chk("R6 clocked mclkr", mfrom, 1'b0);
    chk("R3 up with clocked pin", pwr_up, 1'b1);

    // gap sweep below the timeout: power must hold
    for (int g = TO - 6; g <= TO - 2; g++) begin
      pulse_x(); dropped = 1'b0; mon = 1'b1;
      wclk(g * MP - 4); @(negedge clk);
      mon = 1'b0;
      chk("R4 sync before expiry holds", dropped, 1'b0);
    end
    pulse_x(); dropped = 1'b0; mon = 1'b1;
    wclk((TO - 4) * MP); pulse_r(); wclk((TO - 4) * MP); @(negedge clk);
    mon = 1'b0;
    chk("R4 fsr restarts count", dropped, 1'b0);
    chk("R5 gate stays open", dx_en, 1'b1);

    // gap sweep beyond the timeout: power must drop and gate re-arm
    for (int g = TO + 2; g <= TO + 4; g++) begin
      pulse_x(); dropped = 1'b0; mon = 1'b1;
      wclk(g * MP - 4); @(negedge clk);
      mon = 1'b0;
      chk("R4 expiry drops power", dropped, 1'b1);
      chk("R4 down at expiry", pwr_up, 1'b0);
      pulse_x(); wclk(20); @(negedge clk);
      chk("R3 re-wake", pwr_up, 1'b1);
      chk("R5 re-armed gate", dx_en, 1'b0);
    end

    // force power-down while up
    mr_run = 1'b0; mr_pin = 1'b1; wclk(100); @(negedge clk);
    chk("R2 forced down", pwr_up, 1'b0);
    chk("R2 gate closed", dx_en, 1'b0);
    for (int i = 0; i < 3; i++) begin pulse_x(); wclk(20); end
    mr_pin = 1'b0; wclk(20); @(negedge clk);
    chk("R3 up after release", pwr_up, 1'b1);
    chk("R5 syncs under pdn ignored", dx_en, 1'b0);
    pulse_x(); wclk(20); @(negedge clk);
    chk("R5 one fsx after release", dx_en, 1'b0);
    pulse_x(); wclk(20); @(negedge clk);
    chk("R5 two fsx after release", dx_en, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule